// File: doc/BRIEF.md
# Banked System Address Decoder

This block sits between a CPU's 16-bit address bus and the memories and peripherals of a handheld console. On every access it works out which target region the address falls into and produces a flat physical offset inside that target. Both come from combinational logic driven by the address and the current bank state. One select line per region goes out, and only one of them can be high at a time. When no line is high, the access touched nothing.

The block owns two bank registers: a one-bit video RAM bank and a three-bit work RAM bank. Each sits at its own I/O address and is written through the normal CPU write path. The ROM bank, the external RAM bank, the RAM enable and the clock-register select bit come in from the cartridge controller. For reads, the block also picks the returned byte from the data buses of the selected memories. An unmapped access reads as 0xFF. A write to an unmapped place gives no write strobe.

Top module: `sys_addr_decode`

## Requirements
- R1: Addresses 0x0000-0x3FFF assert select bit 0 (fixed ROM), with physical offset addr[13:0].
- R2: Addresses 0x4000-0x7FFF assert select bit 1 (switchable ROM), with offset {rom_bank, addr[13:0]}.
- R3: Addresses 0x8000-0x9FFF assert select bit 2 (video RAM), with offset {vbank, addr[12:0]}. vbank is bit 0 of a register written at 0xFF4F. It resets to 0 and reads back as {7'h7F, vbank}. It changes only on a write to 0xFF4F.
- R4: Addresses 0xA000-0xBFFF assert select bit 3 (external RAM), with offset {ram_bank, addr[12:0]}, but only when RAM enable is 1 and the clock-register select bit is 0. Otherwise no select is raised, reads return 0xFF and no write strobe is given.
- R5: Addresses 0xC000-0xCFFF assert select bit 4 (work RAM bank 0), with offset addr[11:0].
- R6: Addresses 0xD000-0xDFFF assert select bit 5 (banked work RAM), with offset {wb, addr[11:0]}. wb is the 3-bit register written at 0xFF70 (bits 2:0), except that a value of 0 gives bank 1. The register resets to 0 and reads back as {5'h1F, value}.
- R7: Addresses 0xE000-0xFDFF decode exactly like (addr & 0xDFFF), giving the same select and offset.
- R8: Addresses 0xFE00-0xFE9F assert select bit 6 (object attribute memory), with offset addr[7:0]. Addresses 0xFEA0-0xFEFF select nothing.
- R9: Addresses 0xFF10-0xFF3F assert select bit 7 (sound) and 0xFF80-0xFFFE assert select bit 8 (high RAM), both with offset addr[7:0].
- R10: Address 0xFFFF asserts only select bit 9 (interrupt enable), with offset 0. It never selects high RAM.
- R11: Every other 0xFFxx address, apart from 0xFF4F and 0xFF70, asserts select bit 10 (I/O), with offset addr[7:0].
- R12: The read data is the data bus of the selected region: ROM for bits 0-1, work RAM for bits 4-5. An access with no region selected reads 0xFF, except at the two bank register addresses.
- R13: The write strobe equals the CPU write request while some region is selected, and is 0 otherwise.
- R14: At most one select bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU write request |
| cpu_wdata | input | 8 | CPU write data |
| cart_rom_bank | input | ROMB_W | Switchable ROM bank from cartridge controller |
| cart_ram_bank | input | XRB_W | External RAM bank |
| cart_ram_en | input | 1 | External RAM enabled |
| cart_clk_sel | input | 1 | Clock-register select bit (blocks external RAM when 1) |
| rom_rdata | input | 8 | ROM read data |
| vram_rdata | input | 8 | Video RAM read data |
| xram_rdata | input | 8 | External RAM read data |
| wram_rdata | input | 8 | Work RAM read data |
| oam_rdata | input | 8 | Object attribute memory read data |
| snd_rdata | input | 8 | Sound block read data |
| hram_rdata | input | 8 | High RAM read data |
| ie_rdata | input | 8 | Interrupt enable register read data |
| io_rdata | input | 8 | I/O register port read data |
| region_sel | output | 11 | One-hot region select |
| phys_addr | output | ROMB_W+14 | Physical offset in the selected target |
| mem_we | output | 1 | Write strobe to the selected target |
| cpu_rdata | output | 8 | Read data to the CPU |

## Verification
Some properties are checked on every cycle: the one-hot rule on the selects, the gating of external RAM by enable and clock select, that the banked work RAM offset never points at bank 0, that a fixed-ROM address always selects bit 0, that an unselected access reads 0xFF, and that the video bank holds unless its own address is written. The bench's full address sweeps are needed to show the exact region boundaries, the echo mirror, the offset arithmetic and the read-data routing. Those sweeps are run under several combinations of bank and enable state. Only the bench's write sequences show the bank registers being loaded and read back.

// File: rtl/sad_pkg.sv
`timescale 1ns/1ps
package sad_pkg;
  localparam int NREG     = 11;
  localparam int RG_ROM0  = 0;
  localparam int RG_ROMX  = 1;
  localparam int RG_VRAM  = 2;
  localparam int RG_XRAM  = 3;
  localparam int RG_WRAM0 = 4;
  localparam int RG_WRAMX = 5;
  localparam int RG_OAM   = 6;
  localparam int RG_SND   = 7;
  localparam int RG_HRAM  = 8;
  localparam int RG_IE    = 9;
  localparam int RG_IO    = 10;
endpackage

// File: rtl/sad_region_dec.sv
`timescale 1ns/1ps
module sad_region_dec
  import sad_pkg::*;
#(
  parameter logic [7:0] VREG_LO = 8'h4F,
  parameter logic [7:0] WREG_LO = 8'h70
) (
  input  logic [15:0]     addr,
  input  logic            xram_ok,
  output logic [NREG-1:0] sel,
  output logic [15:0]     fold,
  output logic            is_vreg,
  output logic            is_wreg
);
  logic in_echo;

  always_comb begin
    in_echo = (addr[15:13] == 3'b111) && (addr < 16'hFE00);
    fold    = in_echo ? (addr & 16'hDFFF) : addr;
    is_vreg = (addr == {8'hFF, VREG_LO});
    is_wreg = (addr == {8'hFF, WREG_LO});
  end

  always_comb begin
    sel = '0;
    unique case (fold[15:12])
      4'h0, 4'h1, 4'h2, 4'h3: sel[RG_ROM0] = 1'b1;
      4'h4, 4'h5, 4'h6, 4'h7: sel[RG_ROMX] = 1'b1;
      4'h8, 4'h9:             sel[RG_VRAM] = 1'b1;
      4'hA, 4'hB:             sel[RG_XRAM] = xram_ok;
      4'hC:                   sel[RG_WRAM0] = 1'b1;
      4'hD:                   sel[RG_WRAMX] = 1'b1;
      default: begin
        if (fold[15:8] == 8'hFE) begin
          sel[RG_OAM] = (fold[7:0] < 8'hA0);
        end else if (fold[15:8] == 8'hFF) begin
          if (fold[7:0] == 8'hFF)
            sel[RG_IE] = 1'b1;
          else if (fold[7])
            sel[RG_HRAM] = 1'b1;
          else if (fold[7:0] >= 8'h10 && fold[7:0] <= 8'h3F)
            sel[RG_SND] = 1'b1;
          else
            sel[RG_IO] = !is_vreg && !is_wreg;
        end
      end
    endcase
  end
endmodule

// File: rtl/sad_bank_regs.sv
`timescale 1ns/1ps
module sad_bank_regs #(
  parameter int WB_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [7:0]      wdata,
  input  logic            is_vreg,
  input  logic            is_wreg,
  output logic            vbank_q,
  output logic [WB_W-1:0] wbank_q
);
  logic            vbank_en, wbank_en;
  logic            vbank_d;
  logic [WB_W-1:0] wbank_d;

  always_comb begin
    vbank_en = wr && is_vreg;
    wbank_en = wr && is_wreg;
    vbank_d  = vbank_en ? wdata[0] : vbank_q;
    wbank_d  = wbank_en ? wdata[WB_W-1:0] : wbank_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vbank_q <= 1'b0;
      wbank_q <= '0;
    end else begin
      vbank_q <= vbank_d;
      wbank_q <= wbank_d;
    end
  end
endmodule

// File: rtl/sad_phys_map.sv
`timescale 1ns/1ps
module sad_phys_map
  import sad_pkg::*;
#(
  parameter int ROMB_W = 9,
  parameter int XRB_W  = 4,
  parameter int WB_W   = 3,
  parameter int PA_W   = ROMB_W + 14
) (
  input  logic [NREG-1:0]   sel,
  input  logic [15:0]       fold,
  input  logic [ROMB_W-1:0] rom_bank,
  input  logic [XRB_W-1:0]  ram_bank,
  input  logic              vbank,
  input  logic [WB_W-1:0]   wbank,
  output logic [PA_W-1:0]   phys
);
  logic [WB_W-1:0] wb_eff;

  always_comb begin
    wb_eff = (wbank == '0) ? WB_W'(1) : wbank;
    phys   = '0;
    if (sel[RG_ROM0])  phys = PA_W'(fold[13:0]);
    if (sel[RG_ROMX])  phys = PA_W'({rom_bank, fold[13:0]});
    if (sel[RG_VRAM])  phys = PA_W'({vbank, fold[12:0]});
    if (sel[RG_XRAM])  phys = PA_W'({ram_bank, fold[12:0]});
    if (sel[RG_WRAM0]) phys = PA_W'(fold[11:0]);
    if (sel[RG_WRAMX]) phys = PA_W'({wb_eff, fold[11:0]});
    if (sel[RG_OAM] || sel[RG_SND] || sel[RG_HRAM] || sel[RG_IO])
      phys = PA_W'(fold[7:0]);
  end
endmodule

// File: rtl/sad_rdata_mux.sv
`timescale 1ns/1ps
module sad_rdata_mux
  import sad_pkg::*;
#(
  parameter int WB_W = 3
) (
  input  logic [NREG-1:0] sel,
  input  logic            is_vreg,
  input  logic            is_wreg,
  input  logic            vbank,
  input  logic [WB_W-1:0] wbank,
  input  logic [7:0]      rom_rdata,
  input  logic [7:0]      vram_rdata,
  input  logic [7:0]      xram_rdata,
  input  logic [7:0]      wram_rdata,
  input  logic [7:0]      oam_rdata,
  input  logic [7:0]      snd_rdata,
  input  logic [7:0]      hram_rdata,
  input  logic [7:0]      ie_rdata,
  input  logic [7:0]      io_rdata,
  output logic [7:0]      rdata
);
  always_comb begin
    rdata = 8'hFF;
    if (sel[RG_ROM0] || sel[RG_ROMX])   rdata = rom_rdata;
    if (sel[RG_VRAM])                   rdata = vram_rdata;
    if (sel[RG_XRAM])                   rdata = xram_rdata;
    if (sel[RG_WRAM0] || sel[RG_WRAMX]) rdata = wram_rdata;
    if (sel[RG_OAM])                    rdata = oam_rdata;
    if (sel[RG_SND])                    rdata = snd_rdata;
    if (sel[RG_HRAM])                   rdata = hram_rdata;
    if (sel[RG_IE])                     rdata = ie_rdata;
    if (sel[RG_IO])                     rdata = io_rdata;
    if (is_vreg)                        rdata = {7'h7F, vbank};
    if (is_wreg)                        rdata = {{(8-WB_W){1'b1}}, wbank};
  end
endmodule

// File: rtl/sys_addr_decode.sv
`timescale 1ns/1ps
module sys_addr_decode
  import sad_pkg::*;
#(
  parameter int ROMB_W = 9,
  parameter int XRB_W  = 4,
  parameter int WB_W   = 3,
  parameter logic [7:0] VREG_LO = 8'h4F,
  parameter logic [7:0] WREG_LO = 8'h70
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [15:0]            cpu_addr,
  input  logic                   cpu_wr,
  input  logic [7:0]             cpu_wdata,
  input  logic [ROMB_W-1:0]      cart_rom_bank,
  input  logic [XRB_W-1:0]       cart_ram_bank,
  input  logic                   cart_ram_en,
  input  logic                   cart_clk_sel,
  input  logic [7:0]             rom_rdata,
  input  logic [7:0]             vram_rdata,
  input  logic [7:0]             xram_rdata,
  input  logic [7:0]             wram_rdata,
  input  logic [7:0]             oam_rdata,
  input  logic [7:0]             snd_rdata,
  input  logic [7:0]             hram_rdata,
  input  logic [7:0]             ie_rdata,
  input  logic [7:0]             io_rdata,
  output logic [NREG-1:0]        region_sel,
  output logic [ROMB_W+14-1:0]   phys_addr,
  output logic                   mem_we,
  output logic [7:0]             cpu_rdata
);
  localparam int PA_W = ROMB_W + 14;

  logic [15:0]     fold;
  logic            is_vreg, is_wreg, xram_ok;
  logic            vbank_q;
  logic [WB_W-1:0] wbank_q;

  assign xram_ok = cart_ram_en && !cart_clk_sel;

  sad_region_dec #(.VREG_LO(VREG_LO), .WREG_LO(WREG_LO)) dec_i (
    .addr(cpu_addr), .xram_ok(xram_ok), .sel(region_sel),
    .fold(fold), .is_vreg(is_vreg), .is_wreg(is_wreg)
  );

  sad_bank_regs #(.WB_W(WB_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr(cpu_wr), .wdata(cpu_wdata),
    .is_vreg(is_vreg), .is_wreg(is_wreg),
    .vbank_q(vbank_q), .wbank_q(wbank_q)
  );

  sad_phys_map #(.ROMB_W(ROMB_W), .XRB_W(XRB_W), .WB_W(WB_W), .PA_W(PA_W)) map_i (
    .sel(region_sel), .fold(fold), .rom_bank(cart_rom_bank),
    .ram_bank(cart_ram_bank), .vbank(vbank_q), .wbank(wbank_q),
    .phys(phys_addr)
  );

  sad_rdata_mux #(.WB_W(WB_W)) mux_i (
    .sel(region_sel), .is_vreg(is_vreg), .is_wreg(is_wreg),
    .vbank(vbank_q), .wbank(wbank_q),
    .rom_rdata(rom_rdata), .vram_rdata(vram_rdata), .xram_rdata(xram_rdata),
    .wram_rdata(wram_rdata), .oam_rdata(oam_rdata), .snd_rdata(snd_rdata),
    .hram_rdata(hram_rdata), .ie_rdata(ie_rdata), .io_rdata(io_rdata),
    .rdata(cpu_rdata)
  );

  assign mem_we = cpu_wr && (|region_sel);
endmodule

// File: rtl/sad_checker.sv
`timescale 1ns/1ps
module sad_checker
  import sad_pkg::*;
#(
  parameter int ROMB_W = 9,
  parameter int WB_W   = 3,
  parameter logic [7:0] VREG_LO = 8'h4F,
  parameter logic [7:0] WREG_LO = 8'h70
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [15:0]          cpu_addr,
  input logic                 cpu_wr,
  input logic                 cart_ram_en,
  input logic                 cart_clk_sel,
  input logic [NREG-1:0]      region_sel,
  input logic [ROMB_W+13:0]   phys_addr,
  input logic [7:0]           cpu_rdata,
  input logic                 vbank_q
);
  logic bank_addr;
  assign bank_addr = (cpu_addr == {8'hFF, VREG_LO}) || (cpu_addr == {8'hFF, WREG_LO});

  p_onehot_r14: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(region_sel));

  p_xram_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    region_sel[RG_XRAM] |-> (cart_ram_en && !cart_clk_sel));

  p_wramx_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    region_sel[RG_WRAMX] |-> (phys_addr[WB_W+11:12] != '0));

  p_rom0_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b00) |-> region_sel[RG_ROM0]);

  p_unmapped_ff_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((region_sel == '0) && !bank_addr) |-> (cpu_rdata == 8'hFF));

  p_vbank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && cpu_addr == {8'hFF, VREG_LO}) |=> $stable(vbank_q));
endmodule

bind sys_addr_decode sad_checker #(
  .ROMB_W(ROMB_W), .WB_W(WB_W), .VREG_LO(VREG_LO), .WREG_LO(WREG_LO)
) chk_i (.*);

// File: tb/sys_addr_decode_tb_top.sv
`timescale 1ns/1ps
module sys_addr_decode_tb_top;
  logic        clk, rst_n;
  logic [15:0] cpu_addr;
  logic        cpu_wr;
  logic [7:0]  cpu_wdata;
  logic [8:0]  cart_rom_bank;
  logic [3:0]  cart_ram_bank;
  logic        cart_ram_en, cart_clk_sel;
  logic [10:0] region_sel;
  logic [22:0] phys_addr;
  logic        mem_we;
  logic [7:0]  cpu_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int vb_m = 0;
  int wb_m = 0;

  sys_addr_decode dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cart_rom_bank(cart_rom_bank),
    .cart_ram_bank(cart_ram_bank), .cart_ram_en(cart_ram_en),
    .cart_clk_sel(cart_clk_sel),
    .rom_rdata(8'hA1), .vram_rdata(8'hA2), .xram_rdata(8'hA3),
    .wram_rdata(8'hA4), .oam_rdata(8'hA5), .snd_rdata(8'hA6),
    .hram_rdata(8'hA7), .ie_rdata(8'hA8), .io_rdata(8'hA9),
    .region_sel(region_sel), .phys_addr(phys_addr), .mem_we(mem_we),
    .cpu_rdata(cpu_rdata)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic int fold_of(int a);
    if (a >= 'hE000 && a < 'hFE00) return a & 'hDFFF;
    return a;
  endfunction

  function automatic int exp_idx(int a, bit ok);
    int f = fold_of(a);
    if (f < 'h4000) return 0;
    if (f < 'h8000) return 1;
    if (f < 'hA000) return 2;
    if (f < 'hC000) return ok ? 3 : -1;
    if (f < 'hD000) return 4;
    if (f < 'hE000) return 5;
    if (f >= 'hFE00 && f < 'hFEA0) return 6;
    if (f < 'hFF00) return -1;
    if (f == 'hFFFF) return 9;
    if (f >= 'hFF80) return 8;
    if (f >= 'hFF10 && f <= 'hFF3F) return 7;
    if (f == 'hFF4F || f == 'hFF70) return -1;
    return 10;
  endfunction

  function automatic int exp_phys(int idx, int a, int vb, int wb);
    int f = fold_of(a);
    int eff = (wb == 0) ? 1 : wb;
    case (idx)
      0: return f % 16384;
      1: return int'(cart_rom_bank) * 16384 + f % 16384;
      2: return vb * 8192 + f % 8192;
      3: return int'(cart_ram_bank) * 8192 + f % 8192;
      4: return f % 4096;
      5: return eff * 4096 + f % 4096;
      9: return 0;
      default: return f % 256;
    endcase
  endfunction

  function automatic int exp_rd(int idx, int a, int vb, int wb);
    case (idx)
      0, 1: return 'hA1;
      2: return 'hA2;
      3: return 'hA3;
      4, 5: return 'hA4;
      6: return 'hA5;
      7: return 'hA6;
      8: return 'hA7;
      9: return 'hA8;
      10: return 'hA9;
      default: begin
        if (a == 'hFF4F) return 'hFE | vb;
        if (a == 'hFF70) return 'hF8 | wb;
        return 'hFF;
      end
    endcase
  endfunction

  function automatic string req_of(int idx, int a);
    if (a >= 'hE000 && a < 'hFE00) return "R7";
    case (idx)
      0: return "R1"; 1: return "R2"; 2: return "R3"; 3: return "R4";
      4: return "R5"; 5: return "R6"; 6: return "R8"; 7, 8: return "R9";
      9: return "R10"; 10: return "R11";
      default: return (a >= 'hA000 && a < 'hC000) ? "R4" : "R8";
    endcase
  endfunction

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sweep(int vb, int wb, bit ok);
    for (int a = 0; a < 65536; a++) begin
      int idx, esel;
      cpu_addr = a[15:0];
      #1;
      idx  = exp_idx(a, ok);
      esel = (idx < 0) ? 0 : (1 << idx);
      chk(req_of(idx, a), int'(region_sel), esel, $sformatf("sel @%04h", a));
      if (idx >= 0)
        chk(req_of(idx, a), int'(phys_addr), exp_phys(idx, a, vb, wb),
            $sformatf("phys @%04h", a));
      chk("R12", int'(cpu_rdata), exp_rd(idx, a, vb, wb), $sformatf("rdata @%04h", a));
      // R14 one-hot implied by exact select compare
    end
  endtask

  task automatic wr_cycle(int a, int d);
    @(negedge clk);
    cpu_addr = a[15:0]; cpu_wdata = d[7:0]; cpu_wr = 1;
    #1;
    // R13: strobe only when a region is selected
    chk("R13", int'(mem_we), (exp_idx(a, cart_ram_en && !cart_clk_sel) >= 0) ? 1 : 0,
        $sformatf("we @%04h", a));
    @(negedge clk);
    cpu_wr = 0;
  endtask

  initial begin
    rst_n = 0; cpu_addr = 0; cpu_wr = 0; cpu_wdata = 0;
    cart_rom_bank = 9'h15A; cart_ram_bank = 4'hB;
    cart_ram_en = 1; cart_clk_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state of bank registers (R3, R6)
    cpu_addr = 16'hFF4F; #1; chk("R3", int'(cpu_rdata), 'hFE, "vbank reset");
    cpu_addr = 16'hFF70; #1; chk("R6", int'(cpu_rdata), 'hF8, "wbank reset");

    sweep(0, 0, 1);

    // non-register writes must not touch bank registers (R3, R6)
    wr_cycle('h8000, 'hFF);
    wr_cycle('hFF4E, 'hFF);
    wr_cycle('hA000, 'h00);
    cpu_addr = 16'hFF4F; #1; chk("R3", int'(cpu_rdata), 'hFE, "vbank untouched");
    cpu_addr = 16'hFF70; #1; chk("R6", int'(cpu_rdata), 'hF8, "wbank untouched");

    wr_cycle('hFF4F, 'h03); vb_m = 1;
    wr_cycle('hFF70, 'hFD); wb_m = 5;
    cpu_addr = 16'hFF4F; #1; chk("R3", int'(cpu_rdata), 'hFF, "vbank readback");
    cpu_addr = 16'hFF70; #1; chk("R6", int'(cpu_rdata), 'hFD, "wbank readback");
    cart_ram_en = 0; cart_rom_bank = 9'h0A3; cart_ram_bank = 4'h6;
    wr_cycle('hB123, 'h55);  // R4 disabled external RAM: no strobe
    sweep(vb_m, wb_m, 0);

    wr_cycle('hFF70, 'h07); wb_m = 7;
    wr_cycle('hFF4F, 'h00); vb_m = 0;
    cart_ram_en = 1; cart_clk_sel = 1;
    wr_cycle('hA000, 'h11);  // R4 blocked by clock select
    sweep(vb_m, wb_m, 0);

    cart_clk_sel = 0; cart_rom_bank = 9'h1FF; cart_ram_bank = 4'hF;
    wr_cycle('hC000, 'h22);
    wr_cycle('hFFFF, 'h01);
    sweep(vb_m, wb_m, 1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #20ms;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule